// File: doc/BRIEF.md
# Bus Activity Watchdog with Power-On Delay

This block supervises a host processor by watching the two wires of its serial bus. Each bus command the processor issues restarts a timeout counter. If no command arrives within the selected period, the timeout flag `wdo` rises and stays high until the processor talks again. Time is measured in pulses of an external timebase tick; one tick stands for one millisecond. The counter freezes while the system runs from its backup battery.

A companion timer holds `por_rst` high from reset until a power-on delay has elapsed. A single select bit chooses between a short and a long delay.

The timeout select is written through a strobe from a control register. A written value is held as pending and only becomes the active period at the next bus start condition, or is replaced by the disabled default on reset.

Top module: `busdog_top`

## Requirements
- R1: A start condition is SDA falling while SCL is high on two consecutive clock samples. The restart event is the first SCL high-to-low transition after a start condition, and it clears the timeout counter.
- R2: Further SCL falling edges in the same transaction do not restart the counter. A stop condition (SDA rising while SCL is high) disarms restart detection until the next start condition.
- R3: The active select encodes the timeout in ticks: 2'b00 gives 800, 2'b01 gives 400 and 2'b10 gives 150 (parameters). `wdo` rises on the clock edge that samples the Nth tick after a restart.
- R4: Select 2'b11 disables the watchdog. `wdo` stays low and no count accumulates. This is the value after reset.
- R5: Once high, `wdo` stays high until the next restart event. A restart wins over a tick sampled on the same edge, leaving `wdo` low and the count at zero.
- R6: While `on_battery` is high, ticks are ignored and the count holds its value.
- R7: A `wd_apply` pulse stores `wd_sel` as the pending select and clears the count. The pending select becomes active only at the next start condition. Reset returns the active select to 2'b11.
- R8: `por_rst` is high from reset. It falls after 150 ticks when `por_sel` is 0 and after 800 ticks when `por_sel` is 1. It then stays low until the next reset.
- R9: Immediately after reset, `wdo` is 0 and `por_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power cycle) |
| scl | input | 1 | Bus clock line, already in the clk domain |
| sda | input | 1 | Bus data line, already in the clk domain |
| tick | input | 1 | Timebase pulse, one clock wide, one per millisecond |
| wd_sel | input | 2 | Timeout select written by the control register |
| wd_apply | input | 1 | Strobe that captures `wd_sel` as pending |
| on_battery | input | 1 | High while the system runs on backup battery |
| por_sel | input | 1 | Power-on delay select: 0 short, 1 long |
| wdo | output | 1 | Watchdog timeout flag |
| por_rst | output | 1 | Power-on reset, high until the delay has elapsed |

## Verification
A restart event and a timebase tick can land on the same clock edge, while the count sits one tick short of its limit. If the tick were honoured, `wdo` would fire; with the restart taking priority, it must stay low. The bench provokes this by counting 149 ticks at the 150-tick setting, then dropping SCL after a fresh start in the same cycle as a tick pulse. It checks that `wdo` is low afterwards and that exactly 150 further ticks are needed to raise it.

// File: rtl/busdog_pkg.sv
package busdog_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic armed;
    } bus_st_t;

endpackage

// File: rtl/busdog_bus.sv
module busdog_bus
    import busdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_o,
    output logic restart_o
);

    bus_st_t st_q, st_d;
    logic    stop_w;
    logic    fall_w;

    always_comb begin
        start_o   = st_q.scl & scl & st_q.sda & ~sda;
        stop_w    = st_q.scl & scl & ~st_q.sda & sda;
        fall_w    = st_q.scl & ~scl;
        restart_o = st_q.armed & fall_w;

        st_d     = st_q;
        st_d.scl = scl;
        st_d.sda = sda;
        if (start_o)
            st_d.armed = 1'b1;
        else if (stop_w || restart_o)
            st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl: 1'b1, sda: 1'b1, armed: 1'b0};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/busdog_wdt.sv
module busdog_wdt
    import busdog_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 800,
    parameter int unsigned MID_TICKS   = 400,
    parameter int unsigned SHORT_TICKS = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic       cmd_start,
    input  logic       apply,
    input  logic [1:0] sel_in,
    input  logic       on_battery,
    output logic       wdo
);

    localparam int unsigned MAXT = (LONG_TICKS > MID_TICKS)
        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
        : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
    localparam int unsigned CW = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wdo;
        wd_sel_e       act;
        wd_sel_e       pend;
    } wdt_st_t;

    wdt_st_t       q, d;
    logic [CW-1:0] limit;
    logic [CW-1:0] nxt;

    always_comb begin
        d = q;
        if (apply) begin
            d.pend = wd_sel_e'(sel_in);
            d.cnt  = '0;
        end
        if (cmd_start)
            d.act = d.pend;

        unique case (d.act)
            WD_LONG:  limit = CW'(LONG_TICKS);
            WD_MID:   limit = CW'(MID_TICKS);
            WD_SHORT: limit = CW'(SHORT_TICKS);
            default:  limit = '1;
        endcase

        nxt = q.cnt + 1'b1;
        if (d.act == WD_OFF) begin
            d.cnt = '0;
            d.wdo = 1'b0;
        end else if (tick && !on_battery && !q.wdo && !apply) begin
            d.cnt = nxt;
            if (nxt >= limit)
                d.wdo = 1'b1;
        end

        if (restart) begin
            d.cnt = '0;
            d.wdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, wdo: 1'b0, act: WD_OFF, pend: WD_OFF};
        else        q <= d;
    end

    assign wdo = q.wdo;

endmodule

// File: rtl/busdog_por.sv
module busdog_por #(
    parameter int unsigned SHORT_TICKS = 150,
    parameter int unsigned LONG_TICKS  = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel_long,
    output logic por_rst
);

    localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } por_st_t;

    por_st_t       q, d;
    logic [CW-1:0] limit;
    logic [CW-1:0] nxt;

    always_comb begin
        d     = q;
        limit = sel_long ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
        nxt   = q.cnt + 1'b1;
        if (q.busy && tick) begin
            d.cnt = nxt;
            if (nxt >= limit)
                d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, busy: 1'b1};
        else        q <= d;
    end

    assign por_rst = q.busy;

endmodule

// File: rtl/busdog_top.sv
module busdog_top #(
    parameter int unsigned WD_LONG_TICKS   = 800,
    parameter int unsigned WD_MID_TICKS    = 400,
    parameter int unsigned WD_SHORT_TICKS  = 150,
    parameter int unsigned POR_SHORT_TICKS = 150,
    parameter int unsigned POR_LONG_TICKS  = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic       tick,
    input  logic [1:0] wd_sel,
    input  logic       wd_apply,
    input  logic       on_battery,
    input  logic       por_sel,
    output logic       wdo,
    output logic       por_rst
);

    logic start_w;
    logic restart_w;

    busdog_bus u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl),
        .sda       (sda),
        .start_o   (start_w),
        .restart_o (restart_w)
    );

    busdog_wdt #(
        .LONG_TICKS  (WD_LONG_TICKS),
        .MID_TICKS   (WD_MID_TICKS),
        .SHORT_TICKS (WD_SHORT_TICKS)
    ) u_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .restart    (restart_w),
        .cmd_start  (start_w),
        .apply      (wd_apply),
        .sel_in     (wd_sel),
        .on_battery (on_battery),
        .wdo        (wdo)
    );

    busdog_por #(
        .SHORT_TICKS (POR_SHORT_TICKS),
        .LONG_TICKS  (POR_LONG_TICKS)
    ) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sel_long (por_sel),
        .por_rst  (por_rst)
    );

endmodule

// File: rtl/busdog_chk.sv
module busdog_chk (
    input logic clk,
    input logic rst_n,
    input logic scl,
    input logic start,
    input logic restart,
    input logic on_battery,
    input logic wdo,
    input logic por_rst
);

    // R1: a restart is only ever seen on a falling SCL
    p_restart_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (!scl && $past(scl)));

    // R5: restart leaves the timeout flag low
    p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !wdo);

    // R5: timeout flag holds until restart (or a start that reselects)
    p_wdo_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo && !restart && !start) |=> wdo);

    // R6: on battery the flag cannot rise
    p_battery_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && !wdo) |=> !wdo);

    // R8: power-on reset never re-asserts without a reset
    p_por_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !por_rst |=> !por_rst);

endmodule

bind busdog_top busdog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl        (scl),
    .start      (start_w),
    .restart    (restart_w),
    .on_battery (on_battery),
    .wdo        (wdo),
    .por_rst    (por_rst)
);

// File: tb/tb_busdog_top.sv
module tb_busdog_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {select, ticks after restart, expected wdo}
    localparam logic [14:0] VECS [0:NVEC-1] = '{
        {2'b00, 12'd799, 1'b0},
        {2'b00, 12'd800, 1'b1},
        {2'b01, 12'd399, 1'b0},
        {2'b01, 12'd400, 1'b1},
        {2'b10, 12'd149, 1'b0},
        {2'b10, 12'd150, 1'b1},
        {2'b11, 12'd900, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wd_sel = 2'b11;
    logic       wd_apply = 1'b0;
    logic       on_battery = 1'b0;
    logic       por_sel = 1'b0;
    logic       wdo;
    logic       por_rst;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busdog_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl),
        .sda        (sda),
        .tick       (tick),
        .wd_sel     (wd_sel),
        .wd_apply   (wd_apply),
        .on_battery (on_battery),
        .por_sel    (por_sel),
        .wdo        (wdo),
        .por_rst    (por_rst)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic cmd_begin();
        scl = 1'b1; sda = 1'b1; @(negedge clk);
        sda = 1'b0; @(negedge clk);
        scl = 1'b0; @(negedge clk);
    endtask

    task automatic cmd_end();
        sda = 1'b0; @(negedge clk);
        scl = 1'b1; @(negedge clk);
        sda = 1'b1; @(negedge clk);
    endtask

    task automatic apply_sel(input logic [1:0] s);
        wd_sel = s; wd_apply = 1'b1; @(negedge clk);
        wd_apply = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R9 wdo", wdo, 1'b0);
        chk("R9 por_rst", por_rst, 1'b1);
        pulse(149); chk("R8 por short 149", por_rst, 1'b1);
        pulse(1);   chk("R8 por short 150", por_rst, 1'b0);

        // R4: disabled by default
        cmd_begin(); pulse(900); chk("R4 default off", wdo, 1'b0); cmd_end();

        // R3 / R4 table
        for (int v = 0; v < NVEC; v++) begin
            apply_sel(VECS[v][14:13]);
            cmd_begin();
            pulse(int'(VECS[v][12:1]));
            chk((VECS[v][14:13] == 2'b11) ? "R4 table" : "R3 table", wdo, VECS[v][0]);
            cmd_end();
        end

        // R2: later SCL falls do not restart; stop disarms
        apply_sel(2'b10); cmd_begin(); pulse(100);
        scl = 1'b1; @(negedge clk); scl = 1'b0; @(negedge clk);
        pulse(50); chk("R2 second fall ignored", wdo, 1'b1);
        cmd_end();
        scl = 1'b0; @(negedge clk);
        chk("R2 fall after stop ignored", wdo, 1'b1);
        cmd_begin(); chk("R1 restart clears", wdo, 1'b0);

        // R6: battery freeze
        pulse(100); on_battery = 1'b1; pulse(100); on_battery = 1'b0;
        pulse(49); chk("R6 frozen 149", wdo, 1'b0);
        pulse(1);  chk("R6 frozen 150", wdo, 1'b1);
        cmd_end();

        // R7: apply clears count
        cmd_begin(); pulse(100); apply_sel(2'b10);
        pulse(149); chk("R7 apply cleared 149", wdo, 1'b0);
        pulse(1);   chk("R7 apply cleared 150", wdo, 1'b1);
        cmd_end();

        // R7: pending select waits for a start
        apply_sel(2'b00); cmd_begin(); pulse(200);
        apply_sel(2'b10); pulse(150); chk("R7 pending not active", wdo, 1'b0);
        cmd_end(); cmd_begin(); pulse(150); chk("R7 pending now active", wdo, 1'b1);
        cmd_end();

        // R5: restart and tick on the same edge
        cmd_begin(); pulse(149); cmd_end();
        sda = 1'b0; @(negedge clk);
        scl = 1'b0; tick = 1'b1; @(negedge clk);
        tick = 1'b0; @(negedge clk);
        chk("R5 restart beats tick", wdo, 1'b0);
        pulse(149); chk("R5 count from zero 149", wdo, 1'b0);
        pulse(1);   chk("R5 count from zero 150", wdo, 1'b1);
        pulse(20);  chk("R5 wdo holds", wdo, 1'b1);
        cmd_end();

        // R7 / R8: reset restores disabled select, long power-on delay
        apply_sel(2'b10); cmd_begin(); cmd_end();
        por_sel = 1'b1;
        do_reset();
        chk("R9 wdo after reset", wdo, 1'b0);
        chk("R9 por_rst after reset", por_rst, 1'b1);
        cmd_begin();
        pulse(799); chk("R8 por long 799", por_rst, 1'b1);
        chk("R7 reset restores off", wdo, 1'b0);
        pulse(1);   chk("R8 por long 800", por_rst, 1'b0);
        cmd_end();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule